// File: doc/BRIEF.md
# Bus Transfer History Capture

This block sits beside one master port of an on-chip bus and watches its address phase. Each time the port starts a new, non-sequential transfer that the bus accepts, the block samples that transfer's attributes: the byte strobes, the unaligned flag, the 4-bit sideband code and, on a data-write port, the write-back flag. It keeps the three most recent samples as a short history, with the newest first.

A simple read port exposes the history as three read-only 32-bit words inside a 16-byte window. One parameter selects the port type: instruction, data read, data write, DMA or peripheral. That choice decides which fields carry meaning. Fields without meaning for the selected port type read as zero. One instance is placed per port, and the surrounding register decode routes reads to the right window.

Top module: `bus_xfer_history`

## Requirements
- R1: A capture happens only on a cycle where `obs_hready` is 1 and `obs_htrans` is 2'b10 (non-sequential). The codes 2'b00 (idle), 2'b01 (busy) and 2'b11 (sequential), and any cycle with `obs_hready` at 0, leave all three entries unchanged.
- R2: On a capture, entry 2 takes the old entry 1 and entry 1 takes the old entry 0. Entry 0 takes the new sample, and the old entry 2 is discarded.
- R3: Each entry word holds the byte strobes in bits [7:0], the unaligned flag in bit [8], the sideband code in bits [12:9] and the write-back flag in bit [13].
- R4: Bits [31:14] of every word read back as zero.
- R5: Bit [13] follows `obs_wback` only when the port type is data write. For every other port type it reads as zero.
- R6: When the port type is peripheral, strobe bits [7:4] read as zero and bits [3:0] follow the bus.
- R7: A read with `rd_en` high selects a word by `rd_addr[3:2]`: 0 gives entry 0 (offset 0x0), 1 gives entry 1 (offset 0x4), 2 gives entry 2 (offset 0x8), and 3 (offset 0xC) gives zero. The selected word appears on `rd_data` one cycle later. While `rd_en` is low, `rd_data` holds its value.
- R8: A synchronous active-high `rst` clears all entries and `rd_data` to zero.
- R9: A read issued in the same cycle as a capture returns the history as it stood before the shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| obs_htrans | input | 2 | Observed transfer type |
| obs_hready | input | 1 | Observed ready; a transfer is accepted while high |
| obs_hstrb | input | 8 | Observed byte strobes |
| obs_hunalign | input | 1 | Observed unaligned flag |
| obs_hside | input | 4 | Observed sideband code |
| obs_wback | input | 1 | Observed write-back flag |
| rd_en | input | 1 | Read request |
| rd_addr | input | 4 | Byte offset inside the 16-byte window |
| rd_data | output | 32 | Registered read data |

## Verification
The hardest case to reach is a read that lands in the very cycle a capture shifts the history. It needs a non-sequential accepted beat and a read request to arrive at the same edge. The bench drives both together and expects the word from before the shift, then reads again to see the shifted result. A sweep over every transfer code and ready level, with attribute patterns that vary from beat to beat, reads back all window offsets after each beat. Two instances run this sweep side by side: one set to data write and one set to peripheral, so that each field mask is exercised against the same stimulus.

// File: rtl/bxh_pkg.sv
package bxh_pkg;
  typedef enum logic [2:0] {
    PK_INSTR  = 3'd0,
    PK_DREAD  = 3'd1,
    PK_DWRITE = 3'd2,
    PK_DMA    = 3'd3,
    PK_PERIPH = 3'd4
  } port_kind_e;

  localparam logic [1:0] TRANS_IDLE   = 2'b00;
  localparam logic [1:0] TRANS_BUSY   = 2'b01;
  localparam logic [1:0] TRANS_NONSEQ = 2'b10;
  localparam logic [1:0] TRANS_SEQ    = 2'b11;
endpackage

// File: rtl/bxh_capture.sv
module bxh_capture #(
  parameter bxh_pkg::port_kind_e PORT_KIND = bxh_pkg::PK_DWRITE,
  parameter int STRB_W  = 8,
  parameter int SIDE_W  = 4,
  parameter int ENTRY_W = STRB_W + SIDE_W + 2
) (
  input  logic [1:0]         htrans,
  input  logic               hready,
  input  logic [STRB_W-1:0]  hstrb,
  input  logic               hunalign,
  input  logic [SIDE_W-1:0]  hside,
  input  logic               wback,
  output logic               cap,
  output logic [ENTRY_W-1:0] entry
);
  localparam int HALF_STRB = STRB_W / 2;

  logic [STRB_W-1:0] strb_mask;
  logic              wb_keep;

  generate
    if (PORT_KIND == bxh_pkg::PK_PERIPH) begin : g_per_mask
      assign strb_mask = {{(STRB_W-HALF_STRB){1'b0}}, {HALF_STRB{1'b1}}};
    end else begin : g_full_mask
      assign strb_mask = {STRB_W{1'b1}};
    end
    if (PORT_KIND == bxh_pkg::PK_DWRITE) begin : g_wb
      assign wb_keep = 1'b1;
    end else begin : g_no_wb
      assign wb_keep = 1'b0;
    end
  endgenerate

  always_comb begin
    cap   = hready && (htrans == bxh_pkg::TRANS_NONSEQ);
    entry = {wback & wb_keep, hside, hunalign, hstrb & strb_mask};
  end
endmodule

// File: rtl/bxh_shift_hist.sv
module bxh_shift_hist #(
  parameter int DEPTH   = 3,
  parameter int ENTRY_W = 14
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          cap,
  input  logic [ENTRY_W-1:0]            entry_in,
  output logic [DEPTH-1:0][ENTRY_W-1:0] hist
);
  always_ff @(posedge clk) begin
    if (rst) begin
      hist[0] <= '0;
    end else if (cap) begin
      hist[0] <= entry_in;
    end
  end

  generate
    for (genvar i = 1; i < DEPTH; i++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) begin
          hist[i] <= '0;
        end else if (cap) begin
          hist[i] <= hist[i-1];
        end
      end
    end
  endgenerate

  assert_hold_R1: assert property (@(posedge clk) disable iff (rst)
    !cap |=> $stable(hist));
  assert_newest_R2: assert property (@(posedge clk) disable iff (rst)
    cap |=> hist[0] == $past(entry_in));
  assert_shift_R2: assert property (@(posedge clk) disable iff (rst)
    cap |=> hist[1] == $past(hist[0]));
  assert_clear_R8: assert property (@(posedge clk)
    $past(rst) |-> hist == '0);
endmodule

// File: rtl/bxh_read_port.sv
module bxh_read_port #(
  parameter int DEPTH   = 3,
  parameter int ENTRY_W = 14,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 4
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          rd_en,
  input  logic [ADDR_W-1:0]             rd_addr,
  input  logic [DEPTH-1:0][ENTRY_W-1:0] hist,
  output logic [DATA_W-1:0]             rd_data
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] sel_word;

  always_comb begin
    idx      = rd_addr[ADDR_W-1:2];
    sel_word = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (idx == IDX_W'(i)) sel_word = {{(DATA_W-ENTRY_W){1'b0}}, hist[i]};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else if (rd_en) begin
      rd_data <= sel_word;
    end
  end

  assert_upper_zero_R4: assert property (@(posedge clk) disable iff (rst)
    rd_data[DATA_W-1:ENTRY_W] == '0);
  assert_rd_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));
  assert_rd_first_R7: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_addr[ADDR_W-1:2] == '0) |=> rd_data[ENTRY_W-1:0] == $past(hist[0]));
endmodule

// File: rtl/bus_xfer_history.sv
module bus_xfer_history #(
  parameter bxh_pkg::port_kind_e PORT_KIND = bxh_pkg::PK_DWRITE,
  parameter int DEPTH  = 3,
  parameter int STRB_W = 8,
  parameter int SIDE_W = 4,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        obs_htrans,
  input  logic              obs_hready,
  input  logic [STRB_W-1:0] obs_hstrb,
  input  logic              obs_hunalign,
  input  logic [SIDE_W-1:0] obs_hside,
  input  logic              obs_wback,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int ENTRY_W = STRB_W + SIDE_W + 2;

  logic                          cap;
  logic [ENTRY_W-1:0]            entry;
  logic [DEPTH-1:0][ENTRY_W-1:0] hist;

  bxh_capture #(
    .PORT_KIND(PORT_KIND), .STRB_W(STRB_W), .SIDE_W(SIDE_W), .ENTRY_W(ENTRY_W)
  ) capture_i (
    .htrans(obs_htrans), .hready(obs_hready), .hstrb(obs_hstrb),
    .hunalign(obs_hunalign), .hside(obs_hside), .wback(obs_wback),
    .cap(cap), .entry(entry)
  );

  bxh_shift_hist #(.DEPTH(DEPTH), .ENTRY_W(ENTRY_W)) hist_i (
    .clk(clk), .rst(rst), .cap(cap), .entry_in(entry), .hist(hist)
  );

  bxh_read_port #(
    .DEPTH(DEPTH), .ENTRY_W(ENTRY_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
  ) read_i (
    .clk(clk), .rst(rst), .rd_en(rd_en), .rd_addr(rd_addr),
    .hist(hist), .rd_data(rd_data)
  );

  generate
    if (PORT_KIND == bxh_pkg::PK_PERIPH) begin : g_chk_per
      assert_per_strb_R6: assert property (@(posedge clk) disable iff (rst)
        rd_data[STRB_W-1:STRB_W/2] == '0);
    end
    if (PORT_KIND != bxh_pkg::PK_DWRITE) begin : g_chk_wb
      assert_no_wb_R5: assert property (@(posedge clk) disable iff (rst)
        rd_data[ENTRY_W-1] == 1'b0);
    end
  endgenerate
endmodule

// File: tb/bus_xfer_history_tb_top.sv
module bus_xfer_history_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic [1:0]  htrans;
  logic        hready;
  logic [7:0]  hstrb;
  logic        hunalign;
  logic [3:0]  hside;
  logic        wback;
  logic        rd_en;
  logic [3:0]  rd_addr;
  logic [31:0] rd_dw, rd_pr;

  int checks = 0;
  int errors = 0;
  logic [31:0] m_dw [3];
  logic [31:0] m_pr [3];

  always #2.5 clk = ~clk;

  bus_xfer_history #(.PORT_KIND(bxh_pkg::PK_DWRITE)) dut_i (
    .clk(clk), .rst(rst), .obs_htrans(htrans), .obs_hready(hready),
    .obs_hstrb(hstrb), .obs_hunalign(hunalign), .obs_hside(hside),
    .obs_wback(wback), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_dw)
  );

  bus_xfer_history #(.PORT_KIND(bxh_pkg::PK_PERIPH)) dut_per_i (
    .clk(clk), .rst(rst), .obs_htrans(htrans), .obs_hready(hready),
    .obs_hstrb(hstrb), .obs_hunalign(hunalign), .obs_hside(hside),
    .obs_wback(wback), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_pr)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic void model_clear();
    for (int i = 0; i < 3; i++) begin m_dw[i] = '0; m_pr[i] = '0; end
  endfunction

  // R3 layout, R5 write-back only on data write, R6 peripheral strobe mask
  function automatic void model_push();
    m_dw[2] = m_dw[1]; m_dw[1] = m_dw[0];
    m_pr[2] = m_pr[1]; m_pr[1] = m_pr[0];
    m_dw[0] = 32'(wback) * 32'h2000 + 32'(hside) * 32'h200 + 32'(hunalign) * 32'h100 + 32'(hstrb);
    m_pr[0] = 32'(hside) * 32'h200 + 32'(hunalign) * 32'h100 + 32'(hstrb % 16);
  endfunction

  task automatic read_all(input string req);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      rd_en = 1'b1;
      rd_addr = 4'(i * 4 + (i % 4));
      @(negedge clk);
      rd_en = 1'b0;
      check({req, " R7 dw"}, rd_dw, (i < 3) ? m_dw[i] : 32'h0);
      check({req, " R7 per"}, rd_pr, (i < 3) ? m_pr[i] : 32'h0);
    end
    @(negedge clk);
    check({req, " R7 hold dw"}, rd_dw, 32'h0);
  endtask

  task automatic beat(input logic [1:0] tr, input logic rdy, input int seed);
    @(negedge clk);
    htrans = tr; hready = rdy;
    hstrb = 8'(seed * 37 + 11); hunalign = seed[0] ^ seed[3];
    hside = 4'(seed * 5 + 3); wback = seed[1] ^ seed[4];
    @(negedge clk);
    if (rdy && tr == 2'b10) model_push();
    htrans = 2'b00; hready = 1'b1;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; htrans = 2'b00; hready = 1'b1; hstrb = '0; hunalign = 1'b0;
    hside = '0; wback = 1'b0; rd_en = 1'b0; rd_addr = '0;
    model_clear();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R8 reset dw", rd_dw, 32'h0);
    read_all("R8 reset");

    // R1 R2 R3 R4 R5 R6: sweep every transfer code and ready level
    for (int k = 0; k < 64; k++) begin
      beat(2'(k), k[2], k);
      read_all("R1 R2 R3 sweep");
    end

    // R9: same-cycle read sees pre-shift contents
    beat(2'b10, 1'b1, 77);
    @(negedge clk);
    htrans = 2'b10; hready = 1'b1; hstrb = 8'hA5; hunalign = 1'b1;
    hside = 4'h9; wback = 1'b1; rd_en = 1'b1; rd_addr = 4'h0;
    @(negedge clk);
    check("R9 pre-shift dw", rd_dw, m_dw[0]);
    check("R9 pre-shift per", rd_pr, m_pr[0]);
    model_push();
    htrans = 2'b00; rd_en = 1'b0;
    read_all("R9 after shift");

    // R8: reset mid-run clears history
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    model_clear();
    check("R8 mid reset dw", rd_dw, 32'h0);
    read_all("R8 mid reset");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule